// File: doc/BRIEF.md
# Two-Format Instruction Field Decoder

This purely combinational block takes a 32-bit instruction word and turns it into the controls that the execute and memory stages need. The top bit of the 6-bit opcode selects the format. In register format, the word carries three register fields and a 4-bit condition selector. In immediate format, it carries two 5-bit fields and a 16-bit immediate. The decoder returns the register indices actually read and written, the condition selector, the raw immediate, an ALU operation code, and strobes for register write, memory read and write, jump, subroutine call and return. A further flag marks when the immediate replaces the first operand.

Register 0 reads as zero, so no write to it is ever requested. Register 31 is the stack pointer. A call uses it as the address where the return pc is stored. A return reads the return pc from it and writes it back after the immediate is added. In jump words, the 5-bit rt field carries the condition rather than a register: its top bit must be 0, and the pattern 01000 means always taken. Any opcode outside the defined set raises an illegal flag and suppresses every side effect.

Top module: `insn_field_decoder`

## Requirements
- R1: `imm_fmt` equals instruction bit 31. `imm` equals bits 15:0 when bit 31 is 1 and is zero otherwise. Field positions are: opcode 31:26, rt 25:21, rd 20:16, rs 15:11 and cc 10:7.
- R2: `alu_op` equals opcode bits 3:0 for the register-format arithmetic, insert and logic opcodes (000000 to 000100, 000110, 001000 to 001101) and for their immediate counterparts (100000 to 100011, 101000 to 101101). It is 1110 for conditional move (010100), 0101 for insert-immediate (110100), 0111 for insert-immediate-negated (110101), 0000 for return (111000), and 1111 for every other opcode.
- R3: `src_a` is the rs field for register-format ALU ops, store (010010), conditional move, register jumps (011100) and register calls (011110), and is 0 otherwise. `src_b` is the rt field for the ALU ops of either format, load (010000), store, conditional move, immediate store (110010) and both insert-immediate ops. It is 31 for calls and return, and 0 otherwise.
- R4: `dst` is the rd field for every opcode that writes a register, and 31 for return. `reg_we` is 1 for those opcodes only, and only when `dst` is not 0.
- R5: `mem_rd` is 1 only for load, immediate load (110000) and return. `mem_wr` is 1 only for store, immediate store and the two call opcodes.
- R6: For jumps (011100, 111100), `jump` is 1 and `cond_sel` is rt bits 3:0. `jump_always` is 1 when rt is 01000. A jump with rt bit 4 set is illegal.
- R7: A call (011110, 111110) asserts `jump`, `call`, `jump_always` and `mem_wr`, with `cond_sel` equal to 1000 and `src_b` equal to 31.
- R8: Return (111000) asserts `ret`, `mem_rd` and `reg_we`, with `dst` and `src_b` both equal to 31.
- R9: `use_imm` is 1 for every legal immediate-format word and 0 for every other word.
- R10: `cond_sel` is the cc field for legal register-format words other than jumps and calls, and 0 for immediate-format words other than jumps and calls.
- R11: An undefined opcode sets `illegal`. It then drives `alu_op` to 1111, all indices and `cond_sel` to 0, and every strobe to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word |
| imm_fmt | output | 1 | Word is immediate format |
| src_a | output | 5 | First source register index |
| src_b | output | 5 | Second source register index |
| dst | output | 5 | Destination register index |
| cond_sel | output | 4 | Condition selector |
| imm | output | 16 | Immediate field, zero in register format |
| alu_op | output | 4 | ALU operation code |
| reg_we | output | 1 | Register write request |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| jump | output | 1 | Jump or call |
| jump_always | output | 1 | Jump taken regardless of flags |
| call | output | 1 | Subroutine call |
| ret | output | 1 | Subroutine return |
| use_imm | output | 1 | Immediate replaces first operand |
| illegal | output | 1 | Undefined opcode or bad jump condition |

## Verification
Every one of the 64 opcodes is combined with rt values of 0, 8, 24 and 31 and rd values of 0, 5 and 31. This separates the register-zero write suppression from real writes. It also separates the always-taken jump pattern from other conditions, and a legal jump condition from one with bit 4 set. The low 16 bits alternate between patterns with distinct rs, cc and immediate values. A field taken from the wrong bit range, or a register-format word that leaks its immediate, therefore shows up as a mismatch.

// File: rtl/insn_field_decoder.sv
module insn_field_decoder (
  input  logic [31:0] insn,
  output logic        imm_fmt,
  output logic [4:0]  src_a,
  output logic [4:0]  src_b,
  output logic [4:0]  dst,
  output logic [3:0]  cond_sel,
  output logic [15:0] imm,
  output logic [3:0]  alu_op,
  output logic        reg_we,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        jump,
  output logic        jump_always,
  output logic        call,
  output logic        ret,
  output logic        use_imm,
  output logic        illegal
);
  localparam logic [4:0] SP_IDX   = 5'd31;
  localparam logic [3:0] ALU_ADD  = 4'b0000;
  localparam logic [3:0] ALU_HI   = 4'b0101;
  localparam logic [3:0] ALU_HIN  = 4'b0111;
  localparam logic [3:0] ALU_SEL  = 4'b1110;
  localparam logic [3:0] ALU_NONE = 4'b1111;
  localparam logic [3:0] CC_TRUE  = 4'b1000;

  logic [5:0] opc;
  logic [4:0] f_rt, f_rd, f_rs;
  logic [3:0] f_cc;
  logic       wr;

  assign opc  = insn[31:26];
  assign f_rt = insn[25:21];
  assign f_rd = insn[20:16];
  assign f_rs = insn[15:11];
  assign f_cc = insn[10:7];

  assign imm_fmt = opc[5];
  assign imm     = opc[5] ? insn[15:0] : 16'd0;

  always_comb begin
    src_a    = 5'd0;
    src_b    = 5'd0;
    dst      = 5'd0;
    cond_sel = 4'd0;
    alu_op   = ALU_NONE;
    wr       = 1'b0;
    mem_rd   = 1'b0;
    mem_wr   = 1'b0;
    jump     = 1'b0;
    call     = 1'b0;
    ret      = 1'b0;
    illegal  = 1'b0;
    case (opc)
      6'b000000, 6'b000001, 6'b000010, 6'b000011, 6'b000100, 6'b000110,
      6'b001000, 6'b001001, 6'b001010, 6'b001011, 6'b001100, 6'b001101: begin
        alu_op = opc[3:0]; src_a = f_rs; src_b = f_rt; dst = f_rd;
        wr = 1'b1; cond_sel = f_cc;
      end
      6'b100000, 6'b100001, 6'b100010, 6'b100011,
      6'b101000, 6'b101001, 6'b101010, 6'b101011, 6'b101100, 6'b101101: begin
        alu_op = opc[3:0]; src_b = f_rt; dst = f_rd; wr = 1'b1;
      end
      6'b010000: begin
        src_b = f_rt; dst = f_rd; mem_rd = 1'b1; wr = 1'b1; cond_sel = f_cc;
      end
      6'b010010: begin
        src_a = f_rs; src_b = f_rt; mem_wr = 1'b1; cond_sel = f_cc;
      end
      6'b010100: begin
        alu_op = ALU_SEL; src_a = f_rs; src_b = f_rt; dst = f_rd;
        wr = 1'b1; cond_sel = f_cc;
      end
      6'b011100, 6'b111100: begin
        if (f_rt[4]) illegal = 1'b1;
        else begin
          jump = 1'b1; cond_sel = f_rt[3:0];
          if (!opc[5]) src_a = f_rs;
        end
      end
      6'b011110, 6'b111110: begin
        jump = 1'b1; call = 1'b1; mem_wr = 1'b1; src_b = SP_IDX;
        cond_sel = CC_TRUE;
        if (!opc[5]) src_a = f_rs;
      end
      6'b110000: begin
        dst = f_rd; mem_rd = 1'b1; wr = 1'b1;
      end
      6'b110010: begin
        src_b = f_rt; mem_wr = 1'b1;
      end
      6'b110100, 6'b110101: begin
        alu_op = opc[0] ? ALU_HIN : ALU_HI; src_b = f_rt; dst = f_rd; wr = 1'b1;
      end
      6'b111000: begin
        alu_op = ALU_ADD; ret = 1'b1; src_b = SP_IDX; dst = SP_IDX;
        mem_rd = 1'b1; wr = 1'b1;
      end
      default: illegal = 1'b1;
    endcase
  end

  assign reg_we      = wr && (dst != 5'd0);
  assign use_imm     = opc[5] && !illegal;
  assign jump_always = jump && (cond_sel == CC_TRUE);

  always_comb begin
    a_r11_illegal_quiet: assert (!illegal ||
      !(reg_we || mem_rd || mem_wr || jump || call || ret || use_imm));
    a_r5_rd_wr_excl: assert (!(mem_rd && mem_wr));
    a_r7_call_uses_sp: assert (!call || (src_b == SP_IDX && mem_wr && jump_always));
    a_r8_ret_writes_sp: assert (!ret || (dst == SP_IDX && reg_we && mem_rd));
    a_r4_no_write_r0: assert (!reg_we || dst != 5'd0);
    a_r6_jump_no_write: assert (!jump || !reg_we);
  end
endmodule

// File: tb/insn_field_decoder_tb.sv
module insn_field_decoder_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] insn;
  logic        imm_fmt, reg_we, mem_rd, mem_wr, jump, jump_always, call, ret, use_imm, illegal;
  logic [4:0]  src_a, src_b, dst;
  logic [3:0]  cond_sel, alu_op;
  logic [15:0] imm;

  insn_field_decoder u_dut (
    .insn(insn), .imm_fmt(imm_fmt), .src_a(src_a), .src_b(src_b), .dst(dst),
    .cond_sel(cond_sel), .imm(imm), .alu_op(alu_op), .reg_we(reg_we),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .jump(jump), .jump_always(jump_always),
    .call(call), .ret(ret), .use_imm(use_imm), .illegal(illegal)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic        e_fmt, e_we, e_mrd, e_mwr, e_jmp, e_alw, e_call, e_ret, e_use, e_ill;
  logic [4:0]  e_a, e_b, e_d;
  logic [3:0]  e_cc, e_alu;
  logic [15:0] e_imm;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s insn=%h actual=%0h expected=%0h", req, what, insn, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] w);
    logic [5:0] op;
    logic [4:0] lo, rt, rd, rs;
    logic wr, rarith, iarith;
    op = w[31:26]; lo = op[4:0];
    rt = w[25:21]; rd = w[20:16]; rs = w[15:11];
    e_fmt = w[31]; e_imm = w[31] ? w[15:0] : 16'h0;
    e_a = 0; e_b = 0; e_d = 0; e_cc = 0; e_alu = 4'hF; wr = 0;
    e_mrd = 0; e_mwr = 0; e_jmp = 0; e_call = 0; e_ret = 0; e_ill = 0;
    rarith = !op[5] && (lo <= 4 || lo == 6 || (lo >= 8 && lo <= 13));
    iarith =  op[5] && (lo <= 3 || (lo >= 8 && lo <= 13));
    if (rarith || iarith) begin
      e_alu = op[3:0]; e_b = rt; e_d = rd; wr = 1;
      if (rarith) e_a = rs;
    end else if (op == 6'd16) begin e_b = rt; e_d = rd; e_mrd = 1; wr = 1; end
    else if (op == 6'd18) begin e_a = rs; e_b = rt; e_mwr = 1; end
    else if (op == 6'd20) begin e_alu = 4'hE; e_a = rs; e_b = rt; e_d = rd; wr = 1; end
    else if (lo == 5'd28) begin
      if (rt >= 16) e_ill = 1;
      else begin e_jmp = 1; e_cc = rt[3:0]; if (!op[5]) e_a = rs; end
    end else if (lo == 5'd30) begin
      e_jmp = 1; e_call = 1; e_mwr = 1; e_b = 31; e_cc = 8; if (!op[5]) e_a = rs;
    end else if (op == 6'd48) begin e_d = rd; e_mrd = 1; wr = 1; end
    else if (op == 6'd50) begin e_b = rt; e_mwr = 1; end
    else if (op == 6'd52 || op == 6'd53) begin
      e_alu = (op == 6'd52) ? 4'h5 : 4'h7; e_b = rt; e_d = rd; wr = 1;
    end else if (op == 6'd56) begin
      e_alu = 0; e_ret = 1; e_b = 31; e_d = 31; e_mrd = 1; wr = 1;
    end else e_ill = 1;
    if (!e_ill && !op[5] && !e_jmp) e_cc = w[10:7];
    e_we  = wr && (e_d != 0);
    e_use = op[5] && !e_ill;
    e_alw = e_jmp && (e_cc == 4'd8);
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    insn = w;
    #1;
    model(w);
    chk("R1", "imm_fmt", 32'(imm_fmt), 32'(e_fmt));
    chk("R1", "imm", 32'(imm), 32'(e_imm));
    chk("R2", "alu_op", 32'(alu_op), 32'(e_alu));
    chk("R3", "src_a", 32'(src_a), 32'(e_a));
    chk("R3", "src_b", 32'(src_b), 32'(e_b));
    chk("R4", "dst", 32'(dst), 32'(e_d));
    chk("R4", "reg_we", 32'(reg_we), 32'(e_we));
    chk("R5", "mem_rd", 32'(mem_rd), 32'(e_mrd));
    chk("R5", "mem_wr", 32'(mem_wr), 32'(e_mwr));
    chk("R6", "jump", 32'(jump), 32'(e_jmp));
    chk("R6", "jump_always", 32'(jump_always), 32'(e_alw));
    chk("R7", "call", 32'(call), 32'(e_call));
    chk("R8", "ret", 32'(ret), 32'(e_ret));
    chk("R9", "use_imm", 32'(use_imm), 32'(e_use));
    chk("R10", "cond_sel", 32'(cond_sel), 32'(e_cc));
    chk("R11", "illegal", 32'(illegal), 32'(e_ill));
  endtask

  initial begin
    insn = 32'h0;
    // all-zero word: ADD into register 0, write suppressed (R4)
    apply(32'h0000_0000);
    chk("R4", "zero word reg_we", 32'(reg_we), 32'd0);
    // return with rd field 0 still writes the stack pointer (R8)
    apply({6'b111000, 5'd0, 5'd0, 16'h0004});
    chk("R8", "ret dst", 32'(dst), 32'd31);
    // unconditional register jump (R6)
    apply({6'b011100, 5'b01000, 5'd0, 5'd7, 11'd0});
    chk("R6", "always jump", 32'(jump_always), 32'd1);
    for (int op = 0; op < 64; op++) begin
      for (int ti = 0; ti < 4; ti++) begin
        for (int di = 0; di < 3; di++) begin
          for (int pi = 0; pi < 2; pi++) begin
            logic [4:0] rtv, rdv;
            logic [15:0] lo16;
            rtv  = (ti == 0) ? 5'd0 : (ti == 1) ? 5'd8 : (ti == 2) ? 5'd24 : 5'd31;
            rdv  = (di == 0) ? 5'd0 : (di == 1) ? 5'd5 : 5'd31;
            lo16 = (pi == 0) ? {5'd19, 4'b0110, 7'h55} : {5'd2, 4'b1011, 7'h2A};
            apply({op[5:0], rtv, rdv, lo16});
          end
        end
      end
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule